// File: doc/BRIEF.md
# Latched Event Status Register

This block holds eight sticky event flags that record status conditions for a measurement instrument. Each live flag is set by a one-cycle condition pulse and stays set until software reads the register or issues a clear-status strobe. Five flags follow external conditions:

- operation complete, bit 0
- query fault, bit 2
- device fault, bit 3
- execution fault, bit 4
- syntax fault, bit 5

A sixth flag, bit 7, records that a power-up took place. Positions 1 and 6 are permanently zero.

An eight-bit enable mask selects the flags that take part in a single summary output. The summary is high while any latched flag is also enabled. The mask is loaded through a write port. On a power-up indication the mask is either kept or wiped, as chosen by a persistent power-on-clear control input.

The read port shows the latched flags in the cycle of the read strobe and clears them on the following edge. A condition that arrives in the same cycle as a clear is still recorded.

Top module: `esr_event_status`

## Requirements
- R1: After reset release with no stimulus, rd_data_o is 0 and summary_o is 0, and the enable mask holds 0.
- R2: A one-cycle pulse on evt_i[b], for b in {0,2,3,4,5}, makes rd_data_o[b] (weights 1,4,8,16,32) read 1 from the next clock edge.
- R3: rd_data_o[1] and rd_data_o[6] always read 0, and evt_i[1], evt_i[6] and evt_i[7] set no flag.
- R4: A set flag stays 1 after its condition input returns low, until a read or clear-status strobe.
- R5: A one-cycle pulse on pwr_up_i makes rd_data_o[7] (weight 128) read 1 from the next edge.
- R6: clr_i clears every latched flag at the next edge and leaves the enable mask unchanged.
- R7: While rd_i is high, rd_data_o shows the latched flags; they read 0 after that edge.
- R8: A condition pulse in the same cycle as rd_i or clr_i leaves its flag set after the edge.
- R9: summary_o is 1 exactly when some bit is 1 both in rd_data_o and in the enable mask, with no added cycle.
- R10: mask_we_i high loads mask_wdata_i into the enable mask at the next edge; writing 0 empties the mask.
- R11: pwr_up_i with pon_clear_i=1 clears the enable mask at the next edge, and it overrides a write in the same cycle. With pon_clear_i=0 the mask is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| evt_i | input | 8 | One-cycle condition pulses, one per flag position |
| pwr_up_i | input | 1 | One-cycle power-up indication |
| pon_clear_i | input | 1 | Persistent power-on-clear control for the mask |
| clr_i | input | 1 | Clear-status strobe |
| rd_i | input | 1 | Read strobe; flags clear after this cycle |
| rd_data_o | output | 8 | Current latched flags |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write value |
| summary_o | output | 1 | OR of enabled latched flags |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- Collisions between a condition pulse and a read or clear. A design that gives the clear priority would lose the event.
- Pulses on the tied-zero positions and on bit 7's pulse input. A design that wired every input through would show stray bits.
- Both settings of the power-on-clear control. A wrong polarity would keep the mask when it should be wiped, which shows up at the summary output after the next event. The same probe covers a power-up that collides with a mask write.
- A clear-status that also wiped the mask. This is exposed by an enabled event raising the summary after the clear.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int unsigned ESR_W          = 8;
   localparam logic [7:0]  ESR_PULSE_BITS = 8'h3D;
   localparam int unsigned ESR_PON_BIT    = 7;

   function automatic bit esr_is_live(input logic [7:0] pulse_bits,
                                      input int unsigned pon_bit,
                                      input int unsigned b);
      return pulse_bits[b] || (b == pon_bit);
   endfunction
endpackage

// File: rtl/esr_evt_cell.sv
module esr_evt_cell #(
   parameter bit LIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (LIVE) begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set_i)  q <= 1'b1;
            else if (clr_i)  q <= 1'b0;
         end
         assign q_o = q;

         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q_o);
         p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o && !clr_i) |=> q_o);
         p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !q_o);
      end else begin : g_tied
         logic unused_tie;
         assign unused_tie = ^{clk, rst_n, set_i, clr_i};
         assign q_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/esr_mask_reg.sv
module esr_mask_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pwr_up_i,
   input  logic         pon_clear_i,
   output logic [W-1:0] mask_o
);
   logic         wipe;
   logic [W-1:0] mask_q;

   assign wipe = pwr_up_i && pon_clear_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (wipe)  mask_q <= '0;
      else if (we_i)  mask_q <= wdata_i;
   end
   assign mask_o = mask_q;

   p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !wipe) |=> (mask_o == $past(wdata_i)));
   p_pon_wipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (mask_o == '0));
   p_pon_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_up_i && !pon_clear_i && !we_i) |=> $stable(mask_o));
endmodule

// File: rtl/esr_summary.sv
module esr_summary #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] ev_i,
   input  logic [W-1:0] mask_i,
   output logic         sum_o
);
   assign sum_o = |(ev_i & mask_i);
endmodule

// File: rtl/esr_event_status.sv
module esr_event_status
   import esr_pkg::*;
#(
   parameter int unsigned W          = ESR_W,
   parameter logic [W-1:0] PULSE_BITS = W'(ESR_PULSE_BITS),
   parameter int unsigned PON_BIT    = ESR_PON_BIT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic         pwr_up_i,
   input  logic         pon_clear_i,
   input  logic         clr_i,
   input  logic         rd_i,
   output logic [W-1:0] rd_data_o,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_wdata_i,
   output logic         summary_o
);
   localparam int unsigned LIVE_CNT = $countones(PULSE_BITS) + 1;

   generate
      if (PON_BIT >= W) begin : g_bad_pon
         $error("PON_BIT outside register width");
      end
      if (PULSE_BITS[PON_BIT]) begin : g_bad_overlap
         $error("PON_BIT must not also be a pulse position");
      end
      if (LIVE_CNT > W) begin : g_bad_cnt
         $error("too many live positions");
      end
   endgenerate

   logic [W-1:0] ev;
   logic [W-1:0] mask;
   logic         flush;

   assign flush = clr_i || rd_i;

   for (genvar b = 0; b < W; b++) begin : g_bit
      localparam bit LIVE = esr_is_live(8'(PULSE_BITS), PON_BIT, b);
      logic set_src;
      if (b == PON_BIT) begin : g_pon
         assign set_src = pwr_up_i;
      end else begin : g_evt
         assign set_src = evt_i[b];
      end
      esr_evt_cell #(.LIVE(LIVE)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_src),
         .clr_i (flush),
         .q_o   (ev[b])
      );
   end

   esr_mask_reg #(.W(W)) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (mask_we_i),
      .wdata_i     (mask_wdata_i),
      .pwr_up_i    (pwr_up_i),
      .pon_clear_i (pon_clear_i),
      .mask_o      (mask)
   );

   esr_summary #(.W(W)) u_sum (
      .ev_i   (ev),
      .mask_i (mask),
      .sum_o  (summary_o)
   );

   assign rd_data_o = ev;

   p_summary_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      summary_o |-> (rd_data_o != '0));
   p_pon_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_up_i |=> rd_data_o[PON_BIT]);
   p_read_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !pwr_up_i && ((evt_i & PULSE_BITS) == '0)) |=> (rd_data_o == '0));
   p_dead_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data_o & ~(PULSE_BITS | (W'(1) << PON_BIT))) == '0));
endmodule

// File: tb/sim_esr_event_status.sv
module sim_esr_event_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_i = '0;
   logic       pwr_up_i = 1'b0;
   logic       pon_clear_i = 1'b0;
   logic       clr_i = 1'b0;
   logic       rd_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       mask_we_i = 1'b0;
   logic [7:0] mask_wdata_i = '0;
   logic       summary_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   esr_event_status u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .pwr_up_i(pwr_up_i),
      .pon_clear_i(pon_clear_i), .clr_i(clr_i), .rd_i(rd_i),
      .rd_data_o(rd_data_o), .mask_we_i(mask_we_i),
      .mask_wdata_i(mask_wdata_i), .summary_o(summary_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      evt_i = '0; pwr_up_i = 1'b0; clr_i = 1'b0; rd_i = 1'b0; mask_we_i = 1'b0;
   endtask

   task automatic pulse_evt(input logic [7:0] v);
      evt_i = v; step();
   endtask

   task automatic wr_mask(input logic [7:0] v);
      mask_we_i = 1'b1; mask_wdata_i = v; step();
   endtask

   task automatic do_clr();
      clr_i = 1'b1; step();
   endtask

   task automatic t_reset();
      chk("R1 events", rd_data_o, 8'h00);
      chk("R1 summary", {7'd0, summary_o}, 8'h00);
      pulse_evt(8'h3D);
      chk("R1 mask empty", {7'd0, summary_o}, 8'h00);
      do_clr();
   endtask

   task automatic t_each_bit();
      logic [7:0] w [5] = '{8'h01, 8'h04, 8'h08, 8'h10, 8'h20};
      for (int i = 0; i < 5; i++) begin
         pulse_evt(w[i]);
         chk("R2 set", rd_data_o, w[i]);
         step(); step();
         chk("R4 sticky", rd_data_o, w[i]);
         do_clr();
      end
   endtask

   task automatic t_unused();
      pulse_evt(8'hC2);
      chk("R3 dead inputs", rd_data_o, 8'h00);
      pulse_evt(8'hFF);
      chk("R3 dead positions", rd_data_o & 8'h42, 8'h00);
      do_clr();
   endtask

   task automatic t_pwrup();
      pwr_up_i = 1'b1; step();
      chk("R5 power bit", rd_data_o, 8'h80);
      do_clr();
   endtask

   task automatic t_read();
      pulse_evt(8'h0D);
      rd_i = 1'b1; #1;
      chk("R7 read value", rd_data_o, 8'h0D);
      step();
      chk("R7 cleared after read", rd_data_o, 8'h00);
   endtask

   task automatic t_clr_keeps_mask();
      wr_mask(8'hFF);
      pulse_evt(8'h24);
      chk("R9 summary on", {7'd0, summary_o}, 8'h01);
      do_clr();
      chk("R6 cleared", rd_data_o, 8'h00);
      chk("R6 summary off", {7'd0, summary_o}, 8'h00);
      pulse_evt(8'h01);
      chk("R6 mask kept", {7'd0, summary_o}, 8'h01);
      do_clr();
   endtask

   task automatic t_collide();
      pulse_evt(8'h04);
      rd_i = 1'b1; evt_i = 8'h10; step();
      chk("R8 read collision", rd_data_o, 8'h10);
      clr_i = 1'b1; evt_i = 8'h08; step();
      chk("R8 clear collision", rd_data_o, 8'h08);
      clr_i = 1'b1; pwr_up_i = 1'b1; step();
      chk("R8 power collision", rd_data_o, 8'h80);
      do_clr();
   endtask

   task automatic t_summary();
      wr_mask(8'h04);
      pulse_evt(8'h01);
      chk("R9 unmasked event", {7'd0, summary_o}, 8'h00);
      pulse_evt(8'h04);
      chk("R9 masked event", {7'd0, summary_o}, 8'h01);
      wr_mask(8'h00);
      chk("R10 zero write", {7'd0, summary_o}, 8'h00);
      wr_mask(8'h01);
      chk("R10 load", {7'd0, summary_o}, 8'h01);
      do_clr();
   endtask

   task automatic t_pon();
      wr_mask(8'hFF);
      pon_clear_i = 1'b0; pwr_up_i = 1'b1; step();
      chk("R11 keep summary", {7'd0, summary_o}, 8'h01);
      do_clr();
      pulse_evt(8'h20);
      chk("R11 mask kept", {7'd0, summary_o}, 8'h01);
      do_clr();
      pon_clear_i = 1'b1; pwr_up_i = 1'b1; step();
      chk("R11 wipe events", rd_data_o, 8'h80);
      chk("R11 wiped summary", {7'd0, summary_o}, 8'h00);
      wr_mask(8'hFF);
      do_clr();
      pwr_up_i = 1'b1; mask_we_i = 1'b1; mask_wdata_i = 8'hFF; step();
      chk("R11 wipe beats write", {7'd0, summary_o}, 8'h00);
      pon_clear_i = 1'b0;
      do_clr();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_each_bit();
      t_unused();
      t_pwrup();
      t_read();
      t_clr_keeps_mask();
      t_collide();
      t_summary();
      t_pon();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule